// File: doc/BRIEF.md
# Sync-Presettable Clock Divider Generator

This block produces the divided-clock phase for a group of chips that must share a common cadence. It runs on the fast system clock and watches an external sync level that has already been brought to a clean logic level. Each rising edge of that level, after a two-flop synchronizer, becomes a sync pulse that lasts exactly one system-clock cycle. The sync level may be a periodic clock or a single isolated edge.

The sync pulse loads a programmable phase value into a down-counting rate divider. That value is clamped to the range 2 to R, where R is the division ratio. The counter then free-runs from its loaded value down to 1, reloads R, and marks each reload with a one-cycle strobe. Chips given the same preset stay in phase. Chips given different presets hold a fixed, chosen phase offset. Each later sync edge loads the preset again, so a chip that has slipped out of step is pulled back automatically.

The division ratio is captured only in the first cycle after reset and on sync pulses. Changes to the ratio at any other time have no effect until the next sync pulse.

Top module: `sync_phase_divider`

## Requirements
- R1: The sync level is sampled on rising clock edges through two flops. When the level is low before a clock edge and high after it, `sync_pulse_o` is high for exactly one cycle. That cycle begins at the second clock edge after the level rises.
- R2: A sync level held high produces only one pulse. An isolated edge produces one pulse. Repeated edges produce one pulse each, including edges that toggle every other cycle.
- R3: In the cycle after a sync pulse, `div_state_o` equals the clamped preset. The preset takes priority over the counter's own reload.
- R4: A preset below 2 is applied as 2.
- R5: A preset above the captured ratio is applied as the ratio. A preset equal to the ratio is applied unchanged.
- R6: Between sync pulses the state falls by 1 on each clock. From state 1 it reloads the captured ratio.
- R7: `div_strobe_o` is high exactly in the cycles where `div_state_o` equals 1.
- R8: The ratio is captured only in the first cycle after reset and on sync pulses. Any other change of `ratio_i` leaves the period unchanged. A ratio below 2 is treated as 2.
- R9: While reset is held, `div_state_o`, `sync_pulse_o` and `div_strobe_o` are all 0. After the first clock edge that follows reset release, the state equals the captured ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | External sync level |
| preset_i | input | 6 | Programmed phase preset |
| ratio_i | input | 6 | Division ratio R (legal range 2 to 63) |
| sync_pulse_o | output | 1 | One-cycle pulse for each sync rising edge |
| div_state_o | output | 6 | Current divider state |
| div_strobe_o | output | 1 | Strobe marking the cycle before each reload |

## Verification
The sync input is driven in several patterns: a long held-high level, isolated single edges, a toggle every other cycle, and a pseudo-random sequence. Together these separate correct edge detection from level detection and show that edges spaced at the synchronizer's limit are not dropped. The preset values tried are 0, 1, in range, equal to R, above R, and 63 at R = 63, so each arm of the clamp is exercised on its own. A change of the ratio with no sync edge that follows tells a design that captures R only on a pulse apart from one that tracks the input directly.

// File: rtl/sync_div_pkg.sv
package sync_div_pkg;
  parameter int unsigned DIV_W      = 6;
  parameter int unsigned SYNC_FLOPS = 2;
  parameter int unsigned MIN_STATE  = 2;
endpackage

// File: rtl/sync_edge_detect.sv
module sync_edge_detect #(
  parameter int unsigned STAGES = sync_div_pkg::SYNC_FLOPS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign pulse_o = sync_q[STAGES-1] & ~prev_q;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R1

  AST_HELD_NO_REPULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && sync_q[STAGES-1]) |=> !pulse_o); // R2
endmodule

// File: rtl/preset_clamp.sv
module preset_clamp #(
  parameter int unsigned W   = sync_div_pkg::DIV_W,
  parameter int unsigned MIN = sync_div_pkg::MIN_STATE
) (
  input  logic [W-1:0] preset_i,
  input  logic [W-1:0] ratio_i,
  output logic [W-1:0] ratio_eff_o,
  output logic [W-1:0] preset_eff_o
);
  localparam logic [W-1:0] MinV = W'(MIN);

  always_comb begin
    ratio_eff_o = (ratio_i < MinV) ? MinV : ratio_i;
    if (preset_i < MinV)             preset_eff_o = MinV;
    else if (preset_i > ratio_eff_o) preset_eff_o = ratio_eff_o;
    else                             preset_eff_o = preset_i;
  end
endmodule

// File: rtl/phase_down_counter.sv
module phase_down_counter #(
  parameter int unsigned W = sync_div_pkg::DIV_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] preset_i,
  input  logic [W-1:0] ratio_i,
  output logic [W-1:0] state_o,
  output logic         strobe_o
);
  localparam logic [W-1:0] One = W'(1);

  logic         init_q;
  logic [W-1:0] ratio_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= 1'b0;
      ratio_q <= '0;
      cnt_q   <= '0;
    end else if (!init_q) begin
      init_q  <= 1'b1;
      ratio_q <= ratio_i;
      cnt_q   <= ratio_i;
    end else if (load_i) begin
      ratio_q <= ratio_i;
      cnt_q   <= preset_i;
    end else if (cnt_q == One) begin
      cnt_q   <= ratio_q;
    end else begin
      cnt_q   <= cnt_q - One;
    end
  end

  assign state_o  = cnt_q;
  assign strobe_o = (cnt_q == One);

  AST_STATE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |-> (cnt_q >= One && cnt_q <= ratio_q)); // R6

  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && !load_i && cnt_q > One) |=> cnt_q == $past(cnt_q) - One); // R6

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && !load_i && cnt_q == One) |=> cnt_q == $past(ratio_q)); // R6

  AST_RATIO_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && !load_i) |=> $stable(ratio_q)); // R8
endmodule

// File: rtl/sync_phase_divider.sv
module sync_phase_divider #(
  parameter int unsigned DIV_W  = sync_div_pkg::DIV_W,
  parameter int unsigned STAGES = sync_div_pkg::SYNC_FLOPS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [DIV_W-1:0] preset_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             sync_pulse_o,
  output logic [DIV_W-1:0] div_state_o,
  output logic             div_strobe_o
);
  logic             pulse;
  logic [DIV_W-1:0] ratio_eff;
  logic [DIV_W-1:0] preset_eff;

  sync_edge_detect #(.STAGES(STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .pulse_o (pulse)
  );

  preset_clamp #(.W(DIV_W)) u_clamp (
    .preset_i     (preset_i),
    .ratio_i      (ratio_i),
    .ratio_eff_o  (ratio_eff),
    .preset_eff_o (preset_eff)
  );

  phase_down_counter #(.W(DIV_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (pulse),
    .preset_i (preset_eff),
    .ratio_i  (ratio_eff),
    .state_o  (div_state_o),
    .strobe_o (div_strobe_o)
  );

  assign sync_pulse_o = pulse;

  AST_PRESET_APPLIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_pulse_o |=> div_state_o == $past(preset_eff)); // R3

  AST_PRESET_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_pulse_o |=> div_state_o >= DIV_W'(sync_div_pkg::MIN_STATE)); // R4

  AST_PRESET_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_pulse_o && ratio_i >= DIV_W'(sync_div_pkg::MIN_STATE)) |=> div_state_o <= $past(ratio_i)); // R5

  AST_STROBE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_strobe_o |=> (div_state_o != $past(div_state_o))); // R7
endmodule

// File: tb/sync_phase_divider_bench.sv
module sync_phase_divider_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync = 1'b0;
  logic [5:0] preset = 6'd5;
  logic [5:0] ratio = 6'd10;
  logic       pulse;
  logic [5:0] state;
  logic       strobe;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  typedef struct packed { logic p; logic [5:0] s; logic st; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  sync_phase_divider u_sync_phase_divider (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .preset_i(preset),
    .ratio_i(ratio), .sync_pulse_o(pulse), .div_state_o(state),
    .div_strobe_o(strobe)
  );

  function automatic logic [5:0] max2(input logic [5:0] v);
    return (v < 6'd2) ? 6'd2 : v;
  endfunction

  function automatic logic [5:0] clampv(input logic [5:0] p, input logic [5:0] r);
    if (p < 6'd2) return 6'd2;
    if (p > r)    return r;
    return p;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver-side model: pushes expected outputs for each clock edge
  logic m1, m2, m3, m_init;
  logic [5:0] m_cnt, m_r;
  always @(posedge clk) begin
    if (!rst_n) begin
      m1 = 0; m2 = 0; m3 = 0; m_init = 0; m_cnt = 0; m_r = 0;
      q.delete();
    end else begin
      logic pp;
      exp_t e;
      pp = m2 & ~m3;
      if (!m_init) begin m_r = max2(ratio); m_cnt = m_r; m_init = 1; end
      else if (pp) begin m_r = max2(ratio); m_cnt = clampv(preset, m_r); end
      else if (m_cnt == 6'd1) m_cnt = m_r;
      else m_cnt = m_cnt - 6'd1;
      m3 = m2; m2 = m1; m1 = sync;
      e.p = m2 & ~m3; e.s = m_cnt; e.st = (m_cnt == 6'd1);
      q.push_back(e);
    end
  end

  // Monitor: pops and compares away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R1/R2 sync_pulse", int'(pulse), int'(e.p));
      chk("R3/R6/R8 div_state", int'(state), int'(e.s));
      chk("R7 div_strobe", int'(strobe), int'(e.st));
    end
  end

  task automatic edge_check(input logic [5:0] p, input logic [5:0] r,
                            input logic [5:0] exp_s, input string tag);
    @(negedge clk); preset = p; ratio = r; sync = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pulse after two edges", int'(pulse), 1);
    @(negedge clk);
    chk(tag, int'(state), int'(exp_s));
    chk("R1 pulse one cycle", int'(pulse), 0);
    sync = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R9 reset state", int'(state), 0);
    chk("R9 reset pulse", int'(pulse), 0);
    chk("R9 reset strobe", int'(strobe), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R9 first load ratio", int'(state), 10);
    repeat (30) @(negedge clk);

    edge_check(6'd5, 6'd10, 6'd5, "R3 preset in range");
    // R2: held high, only one pulse (monitor checks each cycle)
    @(negedge clk); sync = 1'b1;
    repeat (25) @(negedge clk);
    sync = 1'b0; repeat (5) @(negedge clk);

    edge_check(6'd0,  6'd10, 6'd2,  "R4 preset 0 floors to 2");
    edge_check(6'd1,  6'd10, 6'd2,  "R4 preset 1 floors to 2");
    edge_check(6'd40, 6'd10, 6'd10, "R5 preset above R");
    edge_check(6'd10, 6'd10, 6'd10, "R5 preset equal to R");

    // R8: ratio change without sync must not alter period
    @(negedge clk); ratio = 6'd20;
    repeat (35) @(negedge clk);
    edge_check(6'd20, 6'd20, 6'd20, "R8 ratio captured on pulse");
    repeat (45) @(negedge clk);
    edge_check(6'd63, 6'd63, 6'd63, "R5 preset 63 at R 63");
    repeat (130) @(negedge clk);
    edge_check(6'd2, 6'd2, 6'd2, "R6 minimum ratio");
    repeat (10) @(negedge clk);
    edge_check(6'd7, 6'd0, 6'd2, "R8 ratio below 2 as 2");
    repeat (10) @(negedge clk);

    // R2: toggle every other cycle
    ratio = 6'd9; preset = 6'd4;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); sync = ~sync;
    end
    // R2/R6: pseudo-random sync and preset stream
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      sync   = $urandom_range(0, 3) == 0 ? ~sync : sync;
      preset = 6'($urandom_range(0, 63));
      if ($urandom_range(0, 15) == 0) ratio = 6'($urandom_range(0, 63));
    end
    sync = 1'b0;
    repeat (10) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule